// File: doc/BRIEF.md
# Dual-Processor Mailbox Messaging Unit

This block lets two processors, A and B, pass 32-bit words and small signals to each other. Both sides use the same clock and reset. Each side has its own simple register port with a write strobe, a read strobe, a word address and read data that follows the address in the same cycle. Each side has four outgoing data slots and four incoming data slots. When one side writes its outgoing slot n, the word lands in the incoming slot n of the other side. Per-channel flags tell the sender when the slot has drained and tell the receiver when a word is waiting.

Besides data, each side can do three more things towards the other side. It can present three flag bits. It can raise any of four general interrupt requests. It can issue a non-maskable interrupt. The receiving side clears pending general interrupts and the non-maskable interrupt by writing ones to them. Each side has one interrupt output, formed from per-channel enables over its empty, full and general-pending conditions.

Word map on each side: 0 to 3 are the outgoing slots (reads return the held word), 4 to 7 are the incoming slots, 8 is status and 9 is control.

Top module: `mbox_unit`

## Requirements
- R1: A write to word address n (0 to 3) on one side stores the word in channel n. From the next cycle, that word reads back at address 4+n on the other side. The receiver's status bit 24+n reads 1 and the sender's status bit 20+n reads 0.
- R2: After reset, each side's status reads 0x00F00000 (all empty bits at 20..23 set), control reads 0, and both interrupt and both NMI outputs are low.
- R3: A read strobe at address 4+n clears the reader's status bit 24+n and sets the sender's status bit 20+n. The change shows two cycles after the read cycle. In the cycle right after the read, both bits still hold their old values.
- R4: A write to an outgoing slot that is not yet empty replaces the held word and leaves the empty and full bits unchanged.
- R5: If an outgoing write lands in the same cycle as the delayed clear from an earlier read of that channel, the write wins: the full bit stays 1 and the new word is held.
- R6: Writing control bits 0..2 on one side makes status bits 0..2 on the other side show that value one cycle later. Status bit 8 of the writer reads 1 for exactly that one cycle after any control write.
- R7: Writing 1 to control bit 16+n raises the other side's status bit 28+n one cycle later. The writer's control bit 16+n reads 1 until the cycle after the pending bit appears, then clears by itself. Writing 0 there has no effect.
- R8: Writing 1 to status bit 28+n clears that pending bit, and writing 0 leaves it. If a clear meets a still-active request from the other side, the set wins.
- R9: Writing 1 to control bit 3 raises the other side's NMI output and its status bit 3 from the next cycle. While the NMI is pending, the writer's control bit 3 reads 1. Only the receiving side writing 1 to its status bit 3 clears it. Writing control bit 3 as 0 has no effect.
- R10: Each side's interrupt output is the OR over n of three terms: (control bit 20+n AND empty n), (control bit 24+n AND full n), and (control bit 28+n AND pending n).
- R11: Writes to incoming-slot addresses and to read-only status bits change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe (side effects only) |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, follows a_addr |
| a_irq | output | 1 | Side A interrupt |
| a_nmi | output | 1 | NMI towards processor A |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe (side effects only) |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, follows b_addr |
| b_irq | output | 1 | Side B interrupt |
| b_nmi | output | 1 | NMI towards processor B |

## Verification
Two pairs of functions can meet in one cycle. In the first pair, a read drains a channel, and its clear arrives one cycle late; the sender's next write can land in exactly that cycle. The bench reads a slot on one side and writes the same channel from the other side on the very next cycle, then expects the full bit to stay set with the new word. In the second pair, a receiver clears a general pending bit in the cycle after the request appeared, while the request is still active; the bench expects the pending bit to survive and to clear only on a later write.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NCH   = 4;
  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int NFLAG = 3;
  localparam int CW    = $clog2(NCH);

  localparam logic [AW-1:0] ADDR_SR = AW'(2 * NCH);
  localparam logic [AW-1:0] ADDR_CR = AW'(2 * NCH + 1);

  // bit positions decoded by the opposite side and by software
  localparam int P_NMI  = 3;
  localparam int P_BUSY = 8;
  localparam int P_GIR  = 16;
  localparam int P_TE   = 20;
  localparam int P_RF   = 24;
  localparam int P_GP   = 28;

  function automatic logic irq_of(input logic [NCH-1:0] en_t, te,
                                  input logic [NCH-1:0] en_r, rf,
                                  input logic [NCH-1:0] en_g, gp);
    return |((en_t & te) | (en_r & rf) | (en_g & gp));
  endfunction

  function automatic logic [DW-1:0] pack_status(input logic [NFLAG-1:0] f,
                                                input logic nmi, busy,
                                                input logic [NCH-1:0] te, rf, gp);
    logic [DW-1:0] r;
    r = '0;
    r[NFLAG-1:0]    = f;
    r[P_NMI]        = nmi;
    r[P_BUSY]       = busy;
    r[P_TE +: NCH]  = te;
    r[P_RF +: NCH]  = rf;
    r[P_GP +: NCH]  = gp;
    return r;
  endfunction

  function automatic logic [DW-1:0] pack_control(input logic [NFLAG-1:0] f,
                                                 input logic nmi,
                                                 input logic [NCH-1:0] req, en_t, en_r, en_g);
    logic [DW-1:0] r;
    r = '0;
    r[NFLAG-1:0]    = f;
    r[P_NMI]        = nmi;
    r[P_GIR +: NCH] = req;
    r[P_TE +: NCH]  = en_t;
    r[P_RF +: NCH]  = en_r;
    r[P_GP +: NCH]  = en_g;
    return r;
  endfunction
endpackage

// File: rtl/mbox_chan.sv
module mbox_chan #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] word,
  output logic             full
);
  logic rd_q;
  logic clear_evt;

  assign clear_evt = rd_q && !wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      full <= 1'b0;
      word <= '0;
    end else begin
      rd_q <= rd;
      if (wr) begin
        word <= wdata;
        full <= 1'b1;
      end else if (clear_evt) begin
        full <= 1'b0;
      end
    end
  end

  assert_deliver_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (full && word == $past(wdata)));

  assert_late_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) ##1 !wr |=> !full);

  assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) ##1 wr |=> full);
endmodule

// File: rtl/mbox_side.sv
module mbox_side
  import mbox_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic                     irq,
  output logic                     nmi,
  input  logic [NCH-1:0][DW-1:0]   tx_data,
  input  logic [NCH-1:0]           tx_full,
  input  logic [NCH-1:0][DW-1:0]   rx_data,
  input  logic [NCH-1:0]           rx_full,
  output logic [NCH-1:0]           tx_wr,
  output logic [NCH-1:0]           rx_rd,
  input  logic [NFLAG-1:0]         peer_f,
  input  logic [NCH-1:0]           peer_req,
  input  logic [NCH-1:0]           peer_gp,
  input  logic                     peer_nmi_set,
  input  logic                     peer_nmi_pend,
  output logic [NFLAG-1:0]         own_f,
  output logic [NCH-1:0]           own_req,
  output logic [NCH-1:0]           own_gp,
  output logic                     own_nmi_set,
  output logic                     own_nmi_pend
);
  logic [NCH-1:0]   en_t, en_r, en_g;
  logic [NFLAG-1:0] shown_f;
  logic             busy;
  logic             wr_cr, wr_sr;
  logic [NCH-1:0]   gp_w1c;
  logic             nmi_w1c;

  assign wr_cr       = wr && (addr == ADDR_CR);
  assign wr_sr       = wr && (addr == ADDR_SR);
  assign gp_w1c      = wr_sr ? wdata[P_GP +: NCH] : '0;
  assign nmi_w1c     = wr_sr && wdata[P_NMI];
  assign own_nmi_set = wr_cr && wdata[P_NMI];

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign tx_wr[i] = wr && (addr == AW'(i));
    assign rx_rd[i] = rd && (addr == AW'(NCH + i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_f        <= '0;
      en_t         <= '0;
      en_r         <= '0;
      en_g         <= '0;
      own_req      <= '0;
      own_gp       <= '0;
      own_nmi_pend <= 1'b0;
      shown_f      <= '0;
      busy         <= 1'b0;
    end else begin
      if (wr_cr) begin
        own_f <= wdata[NFLAG-1:0];
        en_t  <= wdata[P_TE +: NCH];
        en_r  <= wdata[P_RF +: NCH];
        en_g  <= wdata[P_GP +: NCH];
      end
      own_req      <= (own_req & ~peer_gp) | (wr_cr ? wdata[P_GIR +: NCH] : '0);
      own_gp       <= (own_gp & ~gp_w1c) | peer_req;
      own_nmi_pend <= (own_nmi_pend & ~nmi_w1c) | peer_nmi_set;
      shown_f      <= peer_f;
      busy         <= wr_cr;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < AW'(NCH))
      rdata = tx_data[addr[CW-1:0]];
    else if (addr < AW'(2 * NCH))
      rdata = rx_data[addr[CW-1:0]];
    else if (addr == ADDR_SR)
      rdata = pack_status(shown_f, own_nmi_pend, busy, ~tx_full, rx_full, own_gp);
    else if (addr == ADDR_CR)
      rdata = pack_control(own_f, peer_nmi_pend, own_req, en_t, en_r, en_g);
  end

  assign irq = irq_of(en_t, ~tx_full, en_r, rx_full, en_g, own_gp);
  assign nmi = own_nmi_pend;

  assert_gp_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|peer_req) |=> ((own_gp & $past(peer_req)) == $past(peer_req)));

  assert_gp_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sr && peer_req == '0) |=> ((own_gp & $past(wdata[P_GP +: NCH])) == '0));

  assert_nmi_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    peer_nmi_set |=> nmi);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_t == '0 && en_r == '0 && en_g == '0) |-> !irq);

  assert_flag_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (shown_f == $past(peer_f)));
endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
  import mbox_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr,
  input  logic          a_rd,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  output logic          a_nmi,
  input  logic          b_wr,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq,
  output logic          b_nmi
);
  logic [NCH-1:0][DW-1:0] ab_word, ba_word;
  logic [NCH-1:0]         ab_full, ba_full;
  logic [NCH-1:0]         a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
  logic [NFLAG-1:0]       a_f, b_f;
  logic [NCH-1:0]         a_req, b_req, a_gp, b_gp;
  logic                   a_nset, b_nset, a_npend, b_npend;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    mbox_chan #(.WIDTH(DW)) u_ab (
      .clk(clk), .rst_n(rst_n), .wr(a_tx_wr[i]), .wdata(a_wdata),
      .rd(b_rx_rd[i]), .word(ab_word[i]), .full(ab_full[i]));
    mbox_chan #(.WIDTH(DW)) u_ba (
      .clk(clk), .rst_n(rst_n), .wr(b_tx_wr[i]), .wdata(b_wdata),
      .rd(a_rx_rd[i]), .word(ba_word[i]), .full(ba_full[i]));
  end

  mbox_side u_side_a (
    .clk(clk), .rst_n(rst_n), .wr(a_wr), .rd(a_rd), .addr(a_addr), .wdata(a_wdata),
    .rdata(a_rdata), .irq(a_irq), .nmi(a_nmi),
    .tx_data(ab_word), .tx_full(ab_full), .rx_data(ba_word), .rx_full(ba_full),
    .tx_wr(a_tx_wr), .rx_rd(a_rx_rd),
    .peer_f(b_f), .peer_req(b_req), .peer_gp(b_gp),
    .peer_nmi_set(b_nset), .peer_nmi_pend(b_npend),
    .own_f(a_f), .own_req(a_req), .own_gp(a_gp),
    .own_nmi_set(a_nset), .own_nmi_pend(a_npend));

  mbox_side u_side_b (
    .clk(clk), .rst_n(rst_n), .wr(b_wr), .rd(b_rd), .addr(b_addr), .wdata(b_wdata),
    .rdata(b_rdata), .irq(b_irq), .nmi(b_nmi),
    .tx_data(ba_word), .tx_full(ba_full), .rx_data(ab_word), .rx_full(ab_full),
    .tx_wr(b_tx_wr), .rx_rd(b_rx_rd),
    .peer_f(a_f), .peer_req(a_req), .peer_gp(a_gp),
    .peer_nmi_set(a_nset), .peer_nmi_pend(a_npend),
    .own_f(b_f), .own_req(b_req), .own_gp(b_gp),
    .own_nmi_set(b_nset), .own_nmi_pend(b_npend));

  assert_nmi_one_way_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_nset && !b_nset && !a_nmi) |=> (b_nmi && !a_nmi));
endmodule

// File: tb/test_mbox_unit.sv
module test_mbox_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
  logic [3:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, a_nmi, b_irq, b_nmi;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  mbox_unit i_mbox_unit (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq), .a_nmi(a_nmi),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq), .b_nmi(b_nmi));

  // side, channel, data
  localparam logic [34:0] VEC [6] = '{
    {1'b0, 2'd0, 32'hDEAD_BEEF},
    {1'b0, 2'd3, 32'h0000_0001},
    {1'b1, 2'd1, 32'hA5A5_5A5A},
    {1'b1, 2'd2, 32'hFFFF_FFFF},
    {1'b0, 2'd2, 32'h1234_5678},
    {1'b1, 2'd0, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bwr(input bit s, input logic [3:0] ad, input logic [31:0] d);
    if (!s) begin a_wr = 1'b1; a_addr = ad; a_wdata = d; end
    else    begin b_wr = 1'b1; b_addr = ad; b_wdata = d; end
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
  endtask

  task automatic brd(input bit s, input logic [3:0] ad);
    if (!s) begin a_rd = 1'b1; a_addr = ad; end
    else    begin b_rd = 1'b1; b_addr = ad; end
    @(negedge clk);
    a_rd = 1'b0; b_rd = 1'b0;
  endtask

  task automatic peek(input bit s, input logic [3:0] ad, output logic [31:0] v);
    if (!s) a_addr = ad; else b_addr = ad;
    #1;
    v = s ? b_rdata : a_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    peek(1'b0, 4'd8, v); chk("R2 A status", v, 32'h00F0_0000);
    peek(1'b1, 4'd8, v); chk("R2 B status", v, 32'h00F0_0000);
    peek(1'b0, 4'd9, v); chk("R2 A control", v, 32'h0);
    chk("R2 irq/nmi", {28'h0, a_irq, a_nmi, b_irq, b_nmi}, 32'h0);

    // R1 / R3 vector walk
    for (int i = 0; i < 6; i++) begin
      bit s; int ch; logic [31:0] d;
      s = VEC[i][34]; ch = int'(VEC[i][33:32]); d = VEC[i][31:0];
      bwr(s, 4'(ch), d);
      peek(!s, 4'(4 + ch), v); chk("R1 word delivered", v, d);
      peek(!s, 4'd8, v); chk("R1 receiver full", 32'(v[24 + ch]), 32'd1);
      peek(s, 4'd8, v); chk("R1 sender not empty", 32'(v[20 + ch]), 32'd0);
      brd(!s, 4'(4 + ch));
      peek(!s, 4'd8, v); chk("R3 full held one cycle", 32'(v[24 + ch]), 32'd1);
      peek(s, 4'd8, v); chk("R3 empty held one cycle", 32'(v[20 + ch]), 32'd0);
      idle();
      peek(!s, 4'd8, v); chk("R3 full cleared", 32'(v[24 + ch]), 32'd0);
      peek(s, 4'd8, v); chk("R3 empty restored", 32'(v[20 + ch]), 32'd1);
    end

    // R4 overwrite of a pending word
    bwr(1'b0, 4'd2, 32'h1111_1111);
    bwr(1'b0, 4'd2, 32'h2222_2222);
    peek(1'b1, 4'd6, v); chk("R4 overwritten word", v, 32'h2222_2222);
    peek(1'b1, 4'd8, v); chk("R4 full unchanged", 32'(v[26]), 32'd1);
    peek(1'b0, 4'd8, v); chk("R4 empty unchanged", 32'(v[22]), 32'd0);
    brd(1'b1, 4'd6); idle();

    // R5 write meets delayed clear
    bwr(1'b0, 4'd1, 32'hAAAA_0001);
    brd(1'b1, 4'd5);
    bwr(1'b0, 4'd1, 32'hBBBB_0002);
    peek(1'b1, 4'd5, v); chk("R5 new word kept", v, 32'hBBBB_0002);
    peek(1'b1, 4'd8, v); chk("R5 full stays", 32'(v[25]), 32'd1);
    idle();
    peek(1'b1, 4'd8, v); chk("R5 full still set", 32'(v[25]), 32'd1);
    brd(1'b1, 4'd5); idle();

    // R11 ignored writes
    bwr(1'b0, 4'd4, 32'hCAFE_F00D);
    peek(1'b0, 4'd8, v); chk("R11 rx write no flag", v, 32'h00F0_0000);
    peek(1'b0, 4'd4, v); chk("R11 rx word unchanged", v, 32'h0000_0000);
    bwr(1'b0, 4'd8, 32'h00F0_0107);
    peek(1'b0, 4'd8, v); chk("R11 status ro bits", v, 32'h00F0_0000);

    // R6 flag mirror and busy
    bwr(1'b0, 4'd9, 32'h0000_0005);
    peek(1'b0, 4'd8, v); chk("R6 busy set", 32'(v[8]), 32'd1);
    peek(1'b1, 4'd8, w); chk("R6 peer flags old", 32'(w[2:0]), 32'd0);
    idle();
    peek(1'b0, 4'd8, v); chk("R6 busy cleared", 32'(v[8]), 32'd0);
    peek(1'b1, 4'd8, w); chk("R6 peer flags new", 32'(w[2:0]), 32'd5);

    // R7 general request and self clear
    bwr(1'b1, 4'd9, 32'h0002_0000);
    peek(1'b1, 4'd9, v); chk("R7 request held", 32'(v[17]), 32'd1);
    peek(1'b0, 4'd8, w); chk("R7 pending not yet", 32'(w[29]), 32'd0);
    idle();
    peek(1'b0, 4'd8, w); chk("R7 pending raised", 32'(w[29]), 32'd1);
    peek(1'b1, 4'd9, v); chk("R7 request still", 32'(v[17]), 32'd1);
    idle();
    peek(1'b1, 4'd9, v); chk("R7 request self-cleared", 32'(v[17]), 32'd0);
    bwr(1'b0, 4'd8, 32'h0000_0000);
    peek(1'b0, 4'd8, w); chk("R8 zero write keeps", 32'(w[29]), 32'd1);
    bwr(1'b0, 4'd8, 32'h2000_0000);
    peek(1'b0, 4'd8, w); chk("R8 w1c clears", 32'(w[29]), 32'd0);

    // R8 clear meets live request
    bwr(1'b1, 4'd9, 32'h0004_0000);
    bwr(1'b0, 4'd8, 32'h4000_0000);
    peek(1'b0, 4'd8, w); chk("R8 set wins", 32'(w[30]), 32'd1);
    idle();
    bwr(1'b0, 4'd8, 32'h4000_0000);
    peek(1'b0, 4'd8, w); chk("R8 later clear", 32'(w[30]), 32'd0);

    // R9 non-maskable interrupt
    bwr(1'b0, 4'd9, 32'h0000_0008);
    chk("R9 nmi to B", {30'h0, b_nmi, a_nmi}, 32'h2);
    peek(1'b1, 4'd8, v); chk("R9 B status nmi", 32'(v[3]), 32'd1);
    peek(1'b0, 4'd9, v); chk("R9 A control shows", 32'(v[3]), 32'd1);
    bwr(1'b0, 4'd9, 32'h0000_0000);
    chk("R9 zero write no effect", 32'(b_nmi), 32'd1);
    bwr(1'b1, 4'd8, 32'h0000_0008);
    chk("R9 cleared by B", 32'(b_nmi), 32'd0);
    peek(1'b0, 4'd9, v); chk("R9 A control cleared", 32'(v[3]), 32'd0);

    // R10 interrupt output
    bwr(1'b0, 4'd9, 32'h0010_0000);
    chk("R10 empty enable", 32'(a_irq), 32'd1);
    bwr(1'b0, 4'd0, 32'h0000_0077);
    chk("R10 empty gone", 32'(a_irq), 32'd0);
    bwr(1'b1, 4'd9, 32'h0100_0000);
    chk("R10 full enable", 32'(b_irq), 32'd1);
    brd(1'b1, 4'd4); idle();
    chk("R10 full gone", {30'h0, b_irq, a_irq}, 32'h1);
    bwr(1'b0, 4'd9, 32'h0018_0000);
    bwr(1'b1, 4'd9, 32'h8000_0000);
    chk("R10 general enable", 32'(b_irq), 32'd1);
    idle();
    bwr(1'b1, 4'd8, 32'h8000_0000);
    chk("R10 general cleared", 32'(b_irq), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule